// File: doc/BRIEF.md
# Hardwired Phase-Stepped Processor Control Unit

This block is a small hardwired controller with its own register datapath. The datapath holds a program counter, a memory address register, a memory buffer register, an instruction register and one accumulator. The controller steps through four phases: fetch, indirect-address resolution, execute and interrupt entry. Each clock cycle performs one fixed group of register transfers. A 2-bit phase code together with a per-phase step counter selects the group for that cycle. The block drives a single-port synchronous memory. It presents an address with a read or write strobe, and read data returns on the following cycle.

Instruction words are 16 bits wide. Bits 15:12 hold the opcode, bit 11 is the indirect flag and bits 10:0 are the operand address. The block executes four instructions: accumulate-from-memory, increment-memory-and-skip-on-zero, call with the return address stored at the target, and halt. Every other opcode is a no-op. A level interrupt request is honoured between instructions while the interrupt-enable bit is set. Interrupt entry stores the program counter at a fixed save address and jumps to a fixed service address.

Top module: `uop_ctrl_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `icc` is 00 (fetch), `acc` is 0, `halted` is 0 and `mem_wr` is 0. Reset also clears a halt and sets the interrupt-enable bit.
- R2: `icc` encodes the phase as 00 fetch, 01 indirect, 10 execute and 11 interrupt. After a fetch the next phase is indirect when bit 11 of the fetched word is 1, and execute otherwise. After an indirect phase the next phase is execute. After an execute phase the next phase is interrupt when `irq` is high and interrupts are enabled, and fetch otherwise. After an interrupt phase the next phase is fetch.
- R3: A fetch lasts 3 cycles. In its first cycle `mem_addr` equals the program counter and `mem_rd` is 1, and the program counter advances by one during the fetch. The first cycle after reset therefore reads address 0. The buffer register is never loaded from memory in the cycle in which the instruction register copies it.
- R4: `mem_rd` is high exactly one cycle before the buffer register captures `mem_rdata`. `mem_rd` and `mem_wr` are never high together.
- R5: When bit 11 is 1, a 3-cycle indirect phase reads the word at the address field and replaces the address field with bits 10:0 of that word. The upper bits of that word are ignored.
- R6: Opcode 0001 adds the memory word at the operand address to `acc`, modulo 2^16, in 3 execute cycles.
- R7: Opcode 0010 increments the memory word at the operand address, modulo 2^16, and writes it back. The next instruction is skipped when the result is 0. The execute phase takes 4 cycles.
- R8: Opcode 0011 writes the return address (the address after the call) to the operand address and continues at operand address + 1. The execute phase takes 3 cycles.
- R9: Interrupt entry takes 3 cycles. It writes the program counter to address `SAVE_ADDR`, continues at `ISR_ADDR` and clears interrupt enable, so a request that stays high is not taken again.
- R10: Opcode 1111 raises `halted` after its one execute cycle. From then until reset, `icc` stays at 00 and neither strobe is asserted.
- R11: Any opcode other than 0001, 0010, 0011 and 1111 takes one execute cycle, writes no memory and leaves `acc` unchanged.
- R12: An instruction takes 3 cycles of fetch, plus 3 cycles when indirect, plus its execute cycles (ADD 3, ISZ 4, call 3, halt and no-op 1), plus 3 cycles when interrupt entry follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Level interrupt request |
| mem_addr | output | 11 | Memory address |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write strobe; `mem_wdata` is written at `mem_addr` |
| mem_wdata | output | 16 | Write data (buffer register) |
| mem_rdata | input | 16 | Read data from the synchronous memory |
| icc | output | 2 | Current phase code |
| acc | output | 16 | Accumulator value |
| halted | output | 1 | High once a halt has executed |

## Verification
The assertions assume that `mem_rdata` holds the word addressed during the previous `mem_rd` cycle. The bench's memory model registers its read data on that edge to meet this. They also assume that `irq` changes only between clock edges. The bench sets `irq` before reset is released and leaves it unchanged for the whole run. Instruction words are loaded only while reset is held, so the program never changes under a running sequence. The test programs always end in a halt, so every run has a known length in cycles.

// File: rtl/uop_pkg.sv
package uop_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_ADD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_ISZ  = 4'h2;
  localparam logic [OPC_W-1:0] OPC_CALL = 4'h3;
  localparam logic [OPC_W-1:0] OPC_HALT = 4'hF;

  // phase code; the encoding is visible at the top-level port
  typedef enum logic [1:0] {
    ICC_FETCH = 2'b00,
    ICC_IND   = 2'b01,
    ICC_EXEC  = 2'b10,
    ICC_INT   = 2'b11
  } icc_e;

  typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_EA, MAR_SAVE} mar_sel_e;
  typedef enum logic [1:0] {MBR_HOLD, MBR_MEM, MBR_PC, MBR_INC} mbr_sel_e;
  typedef enum logic [2:0] {PC_HOLD, PC_INC, PC_EA, PC_ISR, PC_SKIPZ} pc_op_e;

  // register transfers for one cycle
  typedef struct packed {
    mar_sel_e mar_sel;
    mbr_sel_e mbr_sel;
    pc_op_e   pc_op;
    logic     ir_ld;
    logic     ea_ld;
    logic     acc_add;
    logic     mem_rd;
    logic     mem_wr;
  } uop_ctl_t;

endpackage

// File: rtl/uop_decode.sv
module uop_decode
  import uop_pkg::*;
(
  input  icc_e             icc,
  input  logic [1:0]       step,
  input  logic [OPC_W-1:0] opc,
  input  logic             halted,
  output uop_ctl_t         ctl,
  output logic             last,
  output logic             halt_now
);

  always_comb begin
    ctl      = '0;
    last     = 1'b0;
    halt_now = 1'b0;
    if (!halted) begin
      unique case (icc)
        ICC_FETCH: begin
          unique case (step)
            2'd0: begin ctl.mar_sel = MAR_PC; ctl.mem_rd = 1'b1; end
            2'd1: begin ctl.mbr_sel = MBR_MEM; ctl.pc_op = PC_INC; end
            default: begin ctl.ir_ld = 1'b1; last = 1'b1; end
          endcase
        end
        ICC_IND: begin
          unique case (step)
            2'd0: begin ctl.mar_sel = MAR_EA; ctl.mem_rd = 1'b1; end
            2'd1: ctl.mbr_sel = MBR_MEM;
            default: begin ctl.ea_ld = 1'b1; last = 1'b1; end
          endcase
        end
        ICC_EXEC: begin
          unique case (opc)
            OPC_ADD: begin
              unique case (step)
                2'd0: begin ctl.mar_sel = MAR_EA; ctl.mem_rd = 1'b1; end
                2'd1: ctl.mbr_sel = MBR_MEM;
                default: begin ctl.acc_add = 1'b1; last = 1'b1; end
              endcase
            end
            OPC_ISZ: begin
              unique case (step)
                2'd0: begin ctl.mar_sel = MAR_EA; ctl.mem_rd = 1'b1; end
                2'd1: ctl.mbr_sel = MBR_MEM;
                2'd2: ctl.mbr_sel = MBR_INC;
                default: begin
                  ctl.mem_wr = 1'b1;
                  ctl.pc_op  = PC_SKIPZ;
                  last       = 1'b1;
                end
              endcase
            end
            OPC_CALL: begin
              unique case (step)
                2'd0: begin ctl.mar_sel = MAR_EA; ctl.mbr_sel = MBR_PC; end
                2'd1: begin ctl.pc_op = PC_EA; ctl.mem_wr = 1'b1; end
                default: begin ctl.pc_op = PC_INC; last = 1'b1; end
              endcase
            end
            OPC_HALT: begin
              last     = 1'b1;
              halt_now = 1'b1;
            end
            default: last = 1'b1;
          endcase
        end
        default: begin
          unique case (step)
            2'd0: ctl.mbr_sel = MBR_PC;
            2'd1: begin ctl.mar_sel = MAR_SAVE; ctl.pc_op = PC_ISR; end
            default: begin ctl.mem_wr = 1'b1; last = 1'b1; end
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/uop_seq.sv
module uop_seq
  import uop_pkg::*;
#(
  parameter logic IE_RST = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       irq,
  input  logic       last,
  input  logic       halt_now,
  input  logic       ind_word,
  output icc_e       icc,
  output logic [1:0] step,
  output logic       halted
);

  logic ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      icc    <= ICC_FETCH;
      step   <= 2'd0;
      halted <= 1'b0;
      ie     <= IE_RST;
    end else if (!halted) begin
      if (last) begin
        step <= 2'd0;
        unique case (icc)
          ICC_FETCH: icc <= ind_word ? ICC_IND : ICC_EXEC;
          ICC_IND:   icc <= ICC_EXEC;
          ICC_EXEC: begin
            if (halt_now) begin
              halted <= 1'b1;
              icc    <= ICC_FETCH;
            end else if (irq && ie) begin
              icc <= ICC_INT;
              ie  <= 1'b0;
            end else begin
              icc <= ICC_FETCH;
            end
          end
          default:   icc <= ICC_FETCH;
        endcase
      end else begin
        step <= step + 2'd1;
      end
    end
  end

  // R2: the indirect phase always hands over to execute
  a_r2_ind_to_exec: assert property (@(posedge clk) disable iff (rst)
    (icc == ICC_IND && last) |=> (icc == ICC_EXEC));

  // R9: interrupt entry runs with the enable bit already cleared
  a_r9_ie_cleared: assert property (@(posedge clk) disable iff (rst)
    (icc == ICC_INT) |-> !ie);

  // R10: a halt holds the phase at fetch, step 1
  a_r10_halt_hold: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && icc == ICC_FETCH && step == 2'd0));

  // R12: only execute may reach a fourth step
  a_r12_step_bound: assert property (@(posedge clk) disable iff (rst)
    (icc != ICC_EXEC) |-> (step <= 2'd2));

endmodule

// File: rtl/uop_dpath.sv
module uop_dpath
  import uop_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11,
  parameter logic [AW-1:0] SAVE_A = '0,
  parameter logic [AW-1:0] ISR_A  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  uop_ctl_t         ctl,
  input  logic [DW-1:0]    mem_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [OPC_W-1:0] opc,
  output logic             ind_word,
  output logic [DW-1:0]    acc
);

  logic [AW-1:0] pc, mar, mar_nxt;
  logic [DW-1:0] mbr, ir;
  logic [AW-1:0] ea;

  assign ea = ir[AW-1:0];

  always_comb begin
    unique case (ctl.mar_sel)
      MAR_PC:   mar_nxt = pc;
      MAR_EA:   mar_nxt = ea;
      MAR_SAVE: mar_nxt = SAVE_A;
      default:  mar_nxt = mar;
    endcase
  end

  // a read presents the address being loaded into MAR so data lands next cycle
  assign mem_addr  = (ctl.mar_sel != MAR_HOLD) ? mar_nxt : mar;
  assign mem_wdata = mbr;
  assign opc       = ir[DW-1 -: OPC_W];
  assign ind_word  = mbr[AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      mar <= mar_nxt;
      unique case (ctl.mbr_sel)
        MBR_MEM: mbr <= mem_rdata;
        MBR_PC:  mbr <= DW'(pc);
        MBR_INC: mbr <= mbr + DW'(1);
        default: ;
      endcase
      unique case (ctl.pc_op)
        PC_INC:   pc <= pc + AW'(1);
        PC_EA:    pc <= ea;
        PC_ISR:   pc <= ISR_A;
        PC_SKIPZ: if (mbr == '0) pc <= pc + AW'(1);
        default: ;
      endcase
      if (ctl.ir_ld)
        ir <= mbr;
      else if (ctl.ea_ld)
        ir[AW-1:0] <= mbr[AW-1:0];
      if (ctl.acc_add)
        acc <= acc + mbr;
    end
  end

  // R4: strobes are exclusive
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(ctl.mem_rd && ctl.mem_wr));

  // R4: every read is followed by the buffer capture
  a_r4_rd_then_capture: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_rd |=> (ctl.mbr_sel == MBR_MEM));

  // R3: never load the buffer from memory while the IR copies it
  a_r3_no_mbr_conflict: assert property (@(posedge clk) disable iff (rst)
    !(ctl.mbr_sel == MBR_MEM && ctl.ir_ld));

  // R7: zero result skips one word
  a_r7_skip_zero: assert property (@(posedge clk) disable iff (rst)
    (ctl.pc_op == PC_SKIPZ && mbr == '0) |=> (pc == $past(pc) + AW'(1)));

  // R7: non-zero result does not skip
  a_r7_no_skip: assert property (@(posedge clk) disable iff (rst)
    (ctl.pc_op == PC_SKIPZ && mbr != '0) |=> $stable(pc));

endmodule

// File: rtl/uop_ctrl_core.sv
module uop_ctrl_core
  import uop_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int unsigned SAVE_ADDR = 32'h7F0,
  parameter int unsigned ISR_ADDR  = 32'h7F1,
  parameter logic        IE_RST    = 1'b1,
  localparam int         AW        = DW - OPC_W - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [1:0]    icc,
  output logic [DW-1:0] acc,
  output logic          halted
);

  icc_e             icc_q;
  logic [1:0]       step;
  uop_ctl_t         ctl;
  logic             last, halt_now, ind_word;
  logic [OPC_W-1:0] opc;

  uop_decode u_dec (
    .icc      (icc_q),
    .step     (step),
    .opc      (opc),
    .halted   (halted),
    .ctl      (ctl),
    .last     (last),
    .halt_now (halt_now)
  );

  uop_seq #(.IE_RST(IE_RST)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .last     (last),
    .halt_now (halt_now),
    .ind_word (ind_word),
    .icc      (icc_q),
    .step     (step),
    .halted   (halted)
  );

  uop_dpath #(
    .DW     (DW),
    .AW     (AW),
    .SAVE_A (AW'(SAVE_ADDR)),
    .ISR_A  (AW'(ISR_ADDR))
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .opc       (opc),
    .ind_word  (ind_word),
    .acc       (acc)
  );

  assign mem_rd = ctl.mem_rd;
  assign mem_wr = ctl.mem_wr;
  assign icc    = icc_q;

endmodule

// File: tb/uop_ctrl_core_tb_top.sv
module uop_ctrl_core_tb_top;

  localparam int CLK_NS = 10;
  localparam logic [10:0] SAVE_A = 11'h7F0;
  localparam logic [10:0] ISR_A  = 11'h7F1;

  // {x, y, indirect, expected acc}
  localparam logic [48:0] VEC [6] = '{
    {16'h0003, 16'h0004, 1'b0, 16'h0007},
    {16'h1234, 16'h0F0F, 1'b1, 16'h2143},
    {16'hFFFF, 16'h0001, 1'b0, 16'h0000},
    {16'h8000, 16'h8000, 1'b1, 16'h0000},
    {16'h7FFF, 16'h0001, 1'b0, 16'h8000},
    {16'h0000, 16'h0000, 1'b1, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq = 1'b0;
  logic [10:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [1:0]  icc;
  logic [15:0] acc;
  logic halted;

  logic [15:0] mem [0:2047];
  logic clr = 1'b0, ld_en = 1'b0;
  logic [10:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  int wr_cnt = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  uop_ctrl_core #(.SAVE_ADDR(32'h7F0), .ISR_ADDR(32'h7F1)) dut_i (
    .clk(clk), .rst(rst), .irq(irq),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .icc(icc), .acc(acc), .halted(halted)
  );

  // synchronous single-port memory model
  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 2048; i++) mem[i] <= '0;
      wr_cnt <= 0;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end else begin
      if (mem_wr) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (mem_rd) mem_rdata <= mem[mem_addr];
    end
  end

  function automatic logic [15:0] mk(input logic [3:0] op, input logic ind,
                                     input logic [10:0] a);
    return {op, ind, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [10:0] a, input logic [15:0] d);
    ld_addr = a; ld_data = d; ld_en = 1'b1;
    @(posedge clk); #1 ld_en = 1'b0;
  endtask

  task automatic begin_load();
    @(negedge clk) rst = 1'b1;
    clr = 1'b1;
    @(posedge clk); #1 clr = 1'b0;
  endtask

  // release reset, count cycles until halted is seen
  task automatic run(output int cyc);
    @(negedge clk) rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  int cyc;

  initial begin
    // R1 reset state
    begin_load();
    put(11'h000, mk(4'hF, 1'b0, 11'h0));
    @(negedge clk);
    chk(icc == 2'b00, "R1 icc in reset", icc, 0);
    chk(acc == 16'h0, "R1 acc in reset", acc, 0);
    chk(!halted && !mem_wr, "R1 halted/wr in reset", {halted, mem_wr}, 0);
    rst = 1'b0;
    #1;
    chk(mem_rd && mem_addr == 11'h0, "R3 first read at 0", {mem_rd, mem_addr}, 12'h800);
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(posedge clk); cyc++; @(negedge clk);
    end
    chk(cyc == 4, "R12 halt-only length", cyc, 4);

    // R6/R5/R12 vector table
    foreach (VEC[k]) begin
      logic [15:0] x, y, e;
      logic ind;
      x = VEC[k][48:33]; y = VEC[k][32:17]; ind = VEC[k][16]; e = VEC[k][15:0];
      begin_load();
      put(11'h000, mk(4'h1, ind, ind ? 11'h200 : 11'h100));
      put(11'h001, mk(4'h1, ind, ind ? 11'h201 : 11'h101));
      put(11'h002, mk(4'hF, 1'b0, 11'h0));
      put(11'h100, x);
      put(11'h101, y);
      put(11'h200, 16'hA100);  // R5 upper bits ignored
      put(11'h201, 16'h5101);
      run(cyc);
      chk(acc == e, $sformatf("R6 vec%0d acc", k), acc, e);
      chk(cyc == (ind ? 22 : 16), $sformatf("R12 vec%0d cycles", k), cyc, ind ? 22 : 16);
      chk(wr_cnt == 0, $sformatf("R6 vec%0d no write", k), wr_cnt, 0);
    end

    // R7 zero result skips
    begin_load();
    put(11'h000, mk(4'h2, 1'b0, 11'h100));
    put(11'h001, mk(4'h1, 1'b0, 11'h101));
    put(11'h002, mk(4'hF, 1'b0, 11'h0));
    put(11'h100, 16'hFFFF);
    put(11'h101, 16'h0005);
    run(cyc);
    chk(mem[11'h100] == 16'h0, "R7 wrap to zero", mem[11'h100], 0);
    chk(acc == 16'h0, "R7 skip taken", acc, 0);
    chk(cyc == 11, "R12 ISZ skip cycles", cyc, 11);

    // R7 non-zero result
    begin_load();
    put(11'h000, mk(4'h2, 1'b0, 11'h100));
    put(11'h001, mk(4'h1, 1'b0, 11'h101));
    put(11'h002, mk(4'hF, 1'b0, 11'h0));
    put(11'h100, 16'h0007);
    put(11'h101, 16'h0005);
    run(cyc);
    chk(mem[11'h100] == 16'h8, "R7 incremented", mem[11'h100], 8);
    chk(acc == 16'h5, "R7 no skip", acc, 5);
    chk(cyc == 17, "R12 ISZ cycles", cyc, 17);

    // R8 call
    begin_load();
    put(11'h000, mk(4'h3, 1'b0, 11'h040));
    put(11'h041, mk(4'h1, 1'b0, 11'h101));
    put(11'h042, mk(4'hF, 1'b0, 11'h0));
    put(11'h101, 16'h0005);
    run(cyc);
    chk(mem[11'h040] == 16'h1, "R8 return addr saved", mem[11'h040], 1);
    chk(acc == 16'h5, "R8 continues at target+1", acc, 5);
    chk(cyc == 16, "R12 call cycles", cyc, 16);

    // R9 interrupt with request held high
    begin_load();
    irq = 1'b1;
    put(11'h000, 16'h0000);
    put(ISR_A,          mk(4'h1, 1'b0, 11'h101));
    put(ISR_A + 11'd1,  16'h0000);
    put(ISR_A + 11'd2,  mk(4'hF, 1'b0, 11'h0));
    put(11'h101, 16'h0005);
    run(cyc);
    chk(mem[SAVE_A] == 16'h1, "R9 pc saved", mem[SAVE_A], 1);
    chk(acc == 16'h5, "R9 service routine ran", acc, 5);
    chk(wr_cnt == 1, "R9 taken once", wr_cnt, 1);
    chk(cyc == 21, "R12 interrupt cycles", cyc, 21);

    // R10 halt holds with irq still high
    begin
      int strobes = 0;
      bit bad_icc = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (mem_rd || mem_wr) strobes++;
        if (icc != 2'b00 || !halted) bad_icc = 1'b1;
      end
      chk(strobes == 0, "R10 no strobes after halt", strobes, 0);
      chk(!bad_icc, "R10 fetch held, halted high", bad_icc, 0);
    end
    irq = 1'b0;

    // R11 unknown opcode, with indirect flag, is a no-op
    begin_load();
    put(11'h000, mk(4'h1, 1'b0, 11'h101));
    put(11'h001, mk(4'h5, 1'b1, 11'h123));
    put(11'h002, mk(4'hF, 1'b0, 11'h0));
    put(11'h101, 16'h0005);
    put(11'h123, 16'h0101);
    run(cyc);
    chk(acc == 16'h5, "R11 acc unchanged", acc, 5);
    chk(wr_cnt == 0, "R11 no write", wr_cnt, 0);
    chk(cyc == 17, "R12 R2 no-op indirect cycles", cyc, 17);

    // R1 reset clears halt
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk(!halted && acc == 16'h0, "R1 reset clears halt", {halted, acc}, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog expired act=%0d exp=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule